// File: doc/BRIEF.md
# Coded-Ratio Controller Clock Divider

This block derives a slower controller clock from a fast source clock. A 3-bit select code picks one of eight fixed divide ratios, and some of those ratios are not powers of two. Driver code uses the block as follows:
- It raises the divider reset and presents the code.
- It releases the reset.
- It sets the clock enable.

Two outputs are produced. The first is a one-cycle strobe that marks the end of each divide period. The second is a toggling clock-like level that is high for the second half of each period. When the bypass select is set, the toggling output follows an externally supplied pin clock instead. That pin clock is taken through one register stage.

The control runs on a four-state machine:
- HOLD: the divider reset is asserted.
- GATED: the enable is low.
- BYPASS: the external clock is selected.
- RUN: the divided clock is selected.

The next state depends only on the inputs, with a fixed priority: the divider reset wins over the enable, and the enable wins over the bypass. Any state therefore moves to HOLD on divider reset. Otherwise it moves to GATED on a low enable, to BYPASS on a high bypass select, and to RUN in every other case.

The ratio actually in use is captured only while the divider reset is high. This prevents short, malformed output pulses. Registered copies of the select code and the enable are provided so that software can read its settings back.

Top module: `hclkdiv_ctrl`

## Requirements
- R1: Select code c in 0..7 gives a strobe period of 1, 2, 4, 6, 8, 16, 24, 32 source cycles respectively.
- R2: While `div_rst` is high, both `ctrl_tick` and `ctrl_clk` are low in the same cycle, and the count is held at zero.
- R3: `sel` is captured into the active ratio only on clock edges where `div_rst` is high. A change of `sel` while running has no effect on the output period.
- R4: While `clk_en` is low, both outputs are low in that same cycle. After `clk_en` returns, the count restarts from zero.
- R5: `sel_rb` and `en_rb` equal the `sel` and `clk_en` values of the previous clock edge.
- R6: In BYPASS, `ctrl_tick` is low and `ctrl_clk` equals `ext_clk` as sampled at the previous clock edge.
- R7: For ratio N >= 2, `ctrl_clk` is high in period cycles N/2..N-1 and low in cycles 0..N/2-1. For ratio 1 it stays high.
- R8: The first strobe comes N-1 cycles after the first edge that samples `div_rst` low. It is seen in the cycle whose index within the period is N-1.
- R9: While `rst_n` is low, all outputs, including both readback fields, are zero.
- R10: State priority is divider reset over enable over bypass. With `clk_en` low, a high `byp_sel` does not pass `ext_clk` through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low block reset |
| div_rst | input | 1 | Divider reset; high holds the count and loads `sel` |
| clk_en | input | 1 | Controller clock enable |
| byp_sel | input | 1 | 1 selects the external pin clock for `ctrl_clk` |
| ext_clk | input | 1 | External pin clock |
| sel | input | 3 | Divide ratio select code |
| ctrl_tick | output | 1 | One-cycle strobe at the end of each divide period |
| ctrl_clk | output | 1 | Toggling divided clock, or the registered external clock |
| sel_rb | output | 3 | Readback of the select code |
| en_rb | output | 1 | Readback of the enable |

## Verification
Gating by `div_rst` and `clk_en` acts combinationally. The bench therefore checks it in the same cycle it drives the change, after the falling edge. State changes, ratio capture, readback and the bypass path each take exactly one rising edge. Those checks are made at the falling edge after that rising edge. Period checks number the samples from the first falling edge after release, as index k. A strobe is expected when k mod N equals N-1, and `ctrl_clk` is expected high when k mod N is at least N/2.

// File: rtl/hclkdiv_pkg.sv
`timescale 1ns/1ps
package hclkdiv_pkg;

    localparam int unsigned CODE_W     = 3;
    localparam int unsigned RATIO_CEIL = 32;
    localparam int unsigned RATIO_W    = $clog2(RATIO_CEIL) + 1;

    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,
        ST_GATED  = 2'd1,
        ST_RUN    = 2'd2,
        ST_BYPASS = 2'd3
    } div_state_e;

    // Non-uniform ratio set addressed by the select code
    function automatic logic [RATIO_W-1:0] code_ratio(input logic [CODE_W-1:0] c);
        logic [RATIO_W-1:0] r;
        case (c)
            3'd0:    r = RATIO_W'(1);
            3'd1:    r = RATIO_W'(2);
            3'd2:    r = RATIO_W'(4);
            3'd3:    r = RATIO_W'(6);
            3'd4:    r = RATIO_W'(8);
            3'd5:    r = RATIO_W'(16);
            3'd6:    r = RATIO_W'(24);
            default: r = RATIO_W'(32);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hclkdiv_ratio_dec.sv
`timescale 1ns/1ps
module hclkdiv_ratio_dec
    import hclkdiv_pkg::*;
#(
    parameter int unsigned CNT_W = 5
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  last,
    output logic [CNT_W-1:0]  half_m1,
    output logic              unity
);

    logic [RATIO_W-1:0] ratio;

    always_comb begin
        ratio   = code_ratio(code);
        last    = CNT_W'(ratio - RATIO_W'(1));
        half_m1 = CNT_W'((ratio >> 1) - RATIO_W'(1));
        unity   = (ratio == RATIO_W'(1));
    end

endmodule

// File: rtl/hclkdiv_counter.sv
`timescale 1ns/1ps
module hclkdiv_counter #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] last,
    input  logic [CNT_W-1:0] half_m1,
    output logic             wrap,
    output logic             phase
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (cnt_q == last) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == half_m1) begin
                phase <= 1'b1;
            end
        end
    end

    assign wrap = run && (cnt_q == last);

endmodule

// File: rtl/hclkdiv_out_stage.sv
`timescale 1ns/1ps
module hclkdiv_out_stage
    import hclkdiv_pkg::*;
(
    input  div_state_e state,
    input  logic       div_rst,
    input  logic       clk_en,
    input  logic       wrap,
    input  logic       phase,
    input  logic       unity,
    input  logic       ext_q,
    output logic       ctrl_tick,
    output logic       ctrl_clk
);

    logic pass;

    always_comb begin
        pass      = clk_en && !div_rst;
        ctrl_tick = 1'b0;
        ctrl_clk  = 1'b0;
        unique case (state)
            ST_RUN: begin
                ctrl_tick = wrap && pass;
                ctrl_clk  = (unity || phase) && pass;
            end
            ST_BYPASS: begin
                ctrl_clk  = ext_q && pass;
            end
            ST_HOLD, ST_GATED: begin
                ctrl_tick = 1'b0;
                ctrl_clk  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hclkdiv_ctrl.sv
`timescale 1ns/1ps
module hclkdiv_ctrl
    import hclkdiv_pkg::*;
#(
    parameter int unsigned RATIO_MAX = RATIO_CEIL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_rst,
    input  logic              clk_en,
    input  logic              byp_sel,
    input  logic              ext_clk,
    input  logic [CODE_W-1:0] sel,
    output logic              ctrl_tick,
    output logic              ctrl_clk,
    output logic [CODE_W-1:0] sel_rb,
    output logic              en_rb
);

    localparam int unsigned CNT_W = $clog2(RATIO_MAX);

    div_state_e        state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic              ext_q;
    logic [CNT_W-1:0]  last, half_m1;
    logic              unity, wrap, phase;

    // Next-state selection: divider reset > enable > bypass
    always_comb begin
        if (div_rst)       state_d = ST_HOLD;
        else if (!clk_en)  state_d = ST_GATED;
        else if (byp_sel)  state_d = ST_BYPASS;
        else               state_d = ST_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // Active ratio only loads while the divider is held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            sel_rb <= '0;
            en_rb  <= 1'b0;
            ext_q  <= 1'b0;
        end else begin
            if (div_rst) code_q <= sel;
            sel_rb <= sel;
            en_rb  <= clk_en;
            ext_q  <= ext_clk;
        end
    end

    hclkdiv_ratio_dec #(.CNT_W(CNT_W)) u_dec (
        .code    (code_q),
        .last    (last),
        .half_m1 (half_m1),
        .unity   (unity)
    );

    hclkdiv_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_RUN),
        .last    (last),
        .half_m1 (half_m1),
        .wrap    (wrap),
        .phase   (phase)
    );

    hclkdiv_out_stage u_out (
        .state     (state_q),
        .div_rst   (div_rst),
        .clk_en    (clk_en),
        .wrap      (wrap),
        .phase     (phase),
        .unity     (unity),
        .ext_q     (ext_q),
        .ctrl_tick (ctrl_tick),
        .ctrl_clk  (ctrl_clk)
    );

endmodule

// File: rtl/hclkdiv_ctrl_chk.sv
`timescale 1ns/1ps
module hclkdiv_ctrl_chk
    import hclkdiv_pkg::*;
#(
    parameter int unsigned RATIO_MAX = RATIO_CEIL
) (
    input logic              clk,
    input logic              rst_n,
    input logic              div_rst,
    input logic              clk_en,
    input logic              byp_sel,
    input logic              ext_clk,
    input logic [CODE_W-1:0] sel,
    input logic              ctrl_tick,
    input logic              ctrl_clk,
    input logic [CODE_W-1:0] sel_rb,
    input logic              en_rb
);

    // One cycle of slack for the state register, one for the restart
    localparam int unsigned GAP_LIMIT = RATIO_MAX + 2;
    localparam int unsigned GAP_W     = $clog2(GAP_LIMIT + 2) + 1;

    logic [GAP_W-1:0] gap;
    logic             armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap   <= '0;
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
            if (ctrl_tick || div_rst || !clk_en || byp_sel) gap <= '0;
            else if (gap != {GAP_W{1'b1}})                   gap <= gap + GAP_W'(1);
        end
    end

    assert_gap_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        gap <= GAP_W'(GAP_LIMIT));

    assert_hold_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_rst |-> (!ctrl_tick && !ctrl_clk));

    assert_gate_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> (!ctrl_tick && !ctrl_clk));

    assert_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sel_rb == $past(sel) && en_rb == $past(clk_en)));

    assert_bypass_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(byp_sel) |-> !ctrl_tick);

    assert_bypass_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(byp_sel) && $past(clk_en) && !$past(div_rst) && clk_en && !div_rst)
        |-> (ctrl_clk == $past(ext_clk)));

endmodule

bind hclkdiv_ctrl hclkdiv_ctrl_chk #(.RATIO_MAX(RATIO_MAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_rst   (div_rst),
    .clk_en    (clk_en),
    .byp_sel   (byp_sel),
    .ext_clk   (ext_clk),
    .sel       (sel),
    .ctrl_tick (ctrl_tick),
    .ctrl_clk  (ctrl_clk),
    .sel_rb    (sel_rb),
    .en_rb     (en_rb)
);

// File: tb/tb_hclkdiv_ctrl.sv
`timescale 1ns/1ps
module tb_hclkdiv_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_rst = 1'b1;
    logic       clk_en = 1'b0;
    logic       byp_sel = 1'b0;
    logic       ext_clk = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       ctrl_tick, ctrl_clk, en_rb;
    logic [2:0] sel_rb;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    hclkdiv_ctrl dut (
        .clk(clk), .rst_n(rst_n), .div_rst(div_rst), .clk_en(clk_en),
        .byp_sel(byp_sel), .ext_clk(ext_clk), .sel(sel),
        .ctrl_tick(ctrl_tick), .ctrl_clk(ctrl_clk), .sel_rb(sel_rb), .en_rb(en_rb)
    );

    function automatic int want_ratio(input logic [2:0] c);
        case (c)
            3'd0: return 1;  3'd1: return 2;  3'd2: return 4;  3'd3: return 6;
            3'd4: return 8;  3'd5: return 16; 3'd6: return 24; default: return 32;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Load a code under divider reset, then release; returns at sample k=0
    task automatic start_ratio(input logic [2:0] code);
        @(negedge clk);
        div_rst = 1'b1; sel = code; clk_en = 1'b1; byp_sel = 1'b0;
        @(negedge clk);
        div_rst = 1'b0;
        @(negedge clk);
    endtask

    // Check n samples of a period-r pattern, the first already current
    task automatic check_period(input int r, input int n, input string req);
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            chk(ctrl_tick == ((k % r) == r - 1), {req, " tick"}, ctrl_tick, ((k % r) == r - 1));
            chk(ctrl_clk == ((r == 1) ? 1'b1 : ((k % r) >= r / 2)), {req, "/R7 clk"},
                ctrl_clk, ((r == 1) ? 1 : ((k % r) >= r / 2)));
        end
    endtask

    task automatic t_reset;
        sel = 3'd5; clk_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(ctrl_tick == 1'b0 && ctrl_clk == 1'b0, "R9 outputs in reset", {ctrl_tick, ctrl_clk}, 0);
        chk(sel_rb == 3'd0 && en_rb == 1'b0, "R9 readback in reset", {sel_rb, en_rb}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_all_ratios;
        for (int c = 0; c < 8; c++) begin
            start_ratio(3'(c));
            check_period(want_ratio(3'(c)), 2 * want_ratio(3'(c)), "R1/R8");
        end
    endtask

    task automatic t_sel_ignored;
        start_ratio(3'd2);
        sel = 3'd7;
        check_period(4, 12, "R3 sel change ignored");
        chk(sel_rb == 3'd7, "R5 sel readback", sel_rb, 7);
        start_ratio(3'd7);
        check_period(32, 33, "R3 sel taken after div reset");
    endtask

    task automatic t_div_hold;
        start_ratio(3'd1);
        @(negedge clk);
        div_rst = 1'b1;
        #1;
        chk(ctrl_tick == 1'b0 && ctrl_clk == 1'b0, "R2 same-cycle hold", {ctrl_tick, ctrl_clk}, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(ctrl_tick == 1'b0 && ctrl_clk == 1'b0, "R2 held low", {ctrl_tick, ctrl_clk}, 0);
        end
        div_rst = 1'b0;
        @(negedge clk);
        check_period(2, 4, "R2 restart from zero");
    endtask

    task automatic t_enable_gate;
        start_ratio(3'd3);
        @(negedge clk);
        clk_en = 1'b0;
        #1;
        chk(ctrl_tick == 1'b0 && ctrl_clk == 1'b0, "R4 same-cycle gate", {ctrl_tick, ctrl_clk}, 0);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            chk(ctrl_tick == 1'b0 && ctrl_clk == 1'b0, "R4 gated low", {ctrl_tick, ctrl_clk}, 0);
        end
        chk(en_rb == 1'b0, "R5 enable readback", en_rb, 0);
        clk_en = 1'b1;
        @(negedge clk);
        check_period(6, 6, "R4 restart");
    endtask

    task automatic t_bypass;
        logic [7:0] pat = 8'b1011_0010;
        start_ratio(3'd2);
        byp_sel = 1'b1;
        ext_clk = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ext_clk = pat[i];
            @(negedge clk);
            chk(ctrl_clk == pat[i], "R6 bypass follows pin", ctrl_clk, pat[i]);
            chk(ctrl_tick == 1'b0, "R6 no strobe in bypass", ctrl_tick, 0);
        end
    endtask

    task automatic t_priority;
        @(negedge clk);
        byp_sel = 1'b1; ext_clk = 1'b1; clk_en = 1'b0; div_rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(ctrl_clk == 1'b0, "R10 enable beats bypass", ctrl_clk, 0);
        clk_en = 1'b1; div_rst = 1'b1;
        @(negedge clk);
        chk(ctrl_clk == 1'b0, "R10 div reset beats bypass", ctrl_clk, 0);
        div_rst = 1'b0;
        @(negedge clk);
        chk(ctrl_clk == 1'b1, "R10 bypass once released", ctrl_clk, 1);
        byp_sel = 1'b0; ext_clk = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_all_ratios();
        t_sel_ignored();
        t_div_hold();
        t_enable_gate();
        t_bypass();
        t_priority();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule